// File: doc/BRIEF.md
# Platform Interrupt Controller Register File

This block holds the writable state of a platform-level interrupt controller and turns it into one interrupt request per target context. A synchronous write port (valid, address, data) is decoded against four address windows: per-source priorities, a read-only pending bitmap, per-context enable bitmaps, and a per-context page that holds a threshold and a completion register. Each window is matched by checking that the address is at or above its base and that the distance from the base is below the window size. This test cannot overflow, even near the top of the address space.

Source identifier 0 is reserved and never raises a request, so real sources are numbered 1 to NUM_SOURCES-1. A source becomes pending while its level input is high and it is not claimed. A claim side input (valid plus source ID) marks the source as claimed and drops its pending bit. A completion write releases it. A context requests an interrupt when some pending, unclaimed source is enabled for it and has a priority strictly above the context's threshold. Writes that hit no register, or that carry an illegal value, are discarded. Each one raises a one-cycle error pulse.

Top module: `intc_regfile`

## Requirements
- R1: A write at byte offset 4*k inside the priority window (NUM_SOURCES-1 word registers starting at 0x0) sets the priority of source k+1 to data bits [2:0]. Offset 4*(NUM_SOURCES-1), which is 0x7C by default, lies outside the window.
- R2: Any write inside the pending window (NUM_SOURCES/8 bytes at 0x1000) is rejected with an error pulse and leaves every pending bit unchanged.
- R3: In the enable window at 0x2000, the context is the offset divided by ENABLE_STRIDE (0x80) and the word is (offset mod ENABLE_STRIDE)/4. Bit j of word w enables source 32*w+j. A write with word index below ceil(NUM_SOURCES/32) stores the full 32-bit data. A write with any higher word index is discarded with an error pulse.
- R4: In the context window at 0x200000 (one CONTEXT_STRIDE = 0x1000 page per context), offset 0 is the threshold. A write with data ≤ 7 is stored. A write with a larger value is discarded with an error pulse.
- R5: Offset 4 of a context page is completion. A write with data < NUM_SOURCES clears that source's claimed bit. A write with a larger value is discarded with an error pulse.
- R6: A write to any other offset of a context page, or to an address outside all four windows, changes no state and raises an error pulse.
- R7: `err_o` is high for exactly the one cycle after the clock edge that accepted an illegal write. Legal writes take effect on the edge they are presented at and raise no error.
- R8: On each edge, a source whose level input is high and which is not claimed becomes pending. A claim for source ID s sets s's claimed bit and clears its pending bit. While a source is claimed, its level input does not make it pending.
- R9: `irq_o[c]` is high exactly when some source is pending, unclaimed, enabled for context c, and has a priority strictly greater than context c's threshold. A source of priority 0 never requests.
- R10: Reset clears all priorities, enables, thresholds, pending and claimed bits. `irq_o` and `err_o` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronous to clk_i |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | 32 | Write byte address |
| wr_data_i | input | 32 | Write data |
| src_level_i | input | NUM_SOURCES | Level request per source (bit 0 ignored) |
| claim_valid_i | input | 1 | Claim strobe |
| claim_id_i | input | $clog2(NUM_SOURCES) | Source ID being claimed |
| irq_o | output | NUM_CONTEXTS | Interrupt request per context |
| err_o | output | 1 | One-cycle pulse after an illegal write |

## Verification
The in-line properties check, on every cycle, the following:
- the error pulse only ever follows a write;
- over-range threshold and completion values always produce a pulse;
- a priority write keeps exactly the low three data bits in the addressed source;
- a claim always leaves its source claimed and not pending;
- a request never coexists with a threshold at the maximum priority.

Only the bench's scenarios can show the rest:
- the decoding of each window, including its boundary addresses;
- the strict comparison against the threshold;
- that rejected writes leave the pending, enable and threshold state untouched, as seen through the request outputs;
- the full claim, block and complete sequence.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Width of a priority or threshold value.
  localparam int unsigned PRIO_BITS = 3;
  localparam int unsigned MAX_PRIO  = (1 << PRIO_BITS) - 1;

  // Address window hit by a write.
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_PRIO,
    WIN_PEND,
    WIN_EN,
    WIN_CTX
  } win_e;

endpackage

// File: rtl/intc_write_decode.sv
module intc_write_decode
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SOURCES    = 32,
  parameter int unsigned NUM_CONTEXTS   = 2,
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ENABLE_STRIDE  = 'h80,
  parameter int unsigned CONTEXT_STRIDE = 'h1000,
  parameter logic [ADDR_W-1:0] PRIO_BASE = 'h0,
  parameter logic [ADDR_W-1:0] PEND_BASE = 'h1000,
  parameter logic [ADDR_W-1:0] EN_BASE   = 'h2000,
  parameter logic [ADDR_W-1:0] CTX_BASE  = 'h200000,
  localparam int unsigned IDW       = $clog2(NUM_SOURCES),
  localparam int unsigned CW        = (NUM_CONTEXTS > 1) ? $clog2(NUM_CONTEXTS) : 1,
  localparam int unsigned NUM_WORDS = (NUM_SOURCES + 31) / 32,
  localparam int unsigned WW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              prio_we_o,
  output logic [IDW-1:0]    prio_id_o,
  output logic              en_we_o,
  output logic [CW-1:0]     en_ctx_o,
  output logic [WW-1:0]     en_word_o,
  output logic              thr_we_o,
  output logic              cpl_we_o,
  output logic [CW-1:0]     ctx_o,
  output logic [IDW-1:0]    cpl_id_o,
  output logic              illegal_o
);

  localparam logic [ADDR_W-1:0] PRIO_SPAN = ADDR_W'((NUM_SOURCES - 1) * 4);
  localparam logic [ADDR_W-1:0] PEND_SPAN = ADDR_W'(NUM_SOURCES / 8);
  localparam logic [ADDR_W-1:0] EN_SPAN   = ADDR_W'(NUM_CONTEXTS * ENABLE_STRIDE);
  localparam logic [ADDR_W-1:0] CTX_SPAN  = ADDR_W'(NUM_CONTEXTS * CONTEXT_STRIDE);
  localparam logic [ADDR_W-1:0] EN_MASK   = ADDR_W'(ENABLE_STRIDE - 1);
  localparam logic [ADDR_W-1:0] CTX_MASK  = ADDR_W'(CONTEXT_STRIDE - 1);
  localparam int unsigned EN_SH  = $clog2(ENABLE_STRIDE);
  localparam int unsigned CTX_SH = $clog2(CONTEXT_STRIDE);

  // Overflow-free window test: at or above base, distance below span.
  function automatic logic hit(input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] base,
                               input logic [ADDR_W-1:0] span);
    return (a >= base) && ((a - base) < span);
  endfunction

  win_e              win;
  logic              en_ok;
  logic [ADDR_W-1:0] ctx_off;
  logic              thr_sel;
  logic              cpl_sel;

  always_comb begin
    if (hit(wr_addr_i, PRIO_BASE, PRIO_SPAN))      win = WIN_PRIO;
    else if (hit(wr_addr_i, PEND_BASE, PEND_SPAN)) win = WIN_PEND;
    else if (hit(wr_addr_i, EN_BASE, EN_SPAN))     win = WIN_EN;
    else if (hit(wr_addr_i, CTX_BASE, CTX_SPAN))   win = WIN_CTX;
    else                                           win = WIN_NONE;
  end

  assign en_ok   = ((wr_addr_i & EN_MASK) >> 2) < ADDR_W'(NUM_WORDS);
  assign ctx_off = wr_addr_i & CTX_MASK;
  assign thr_sel = (ctx_off == ADDR_W'(0)) && (wr_data_i <= DATA_W'(MAX_PRIO));
  assign cpl_sel = (ctx_off == ADDR_W'(4)) && (wr_data_i < DATA_W'(NUM_SOURCES));

  assign prio_we_o = wr_valid_i && (win == WIN_PRIO);
  assign prio_id_o = IDW'((wr_addr_i - PRIO_BASE) >> 2) + IDW'(1);
  assign en_we_o   = wr_valid_i && (win == WIN_EN) && en_ok;
  assign en_ctx_o  = CW'((wr_addr_i - EN_BASE) >> EN_SH);
  assign en_word_o = WW'((wr_addr_i & EN_MASK) >> 2);
  assign ctx_o     = CW'((wr_addr_i - CTX_BASE) >> CTX_SH);
  assign thr_we_o  = wr_valid_i && (win == WIN_CTX) && thr_sel;
  assign cpl_we_o  = wr_valid_i && (win == WIN_CTX) && cpl_sel;
  assign cpl_id_o  = IDW'(wr_data_i);

  assign illegal_o = wr_valid_i &&
                     ((win == WIN_NONE) || (win == WIN_PEND) ||
                      ((win == WIN_EN) && !en_ok) ||
                      ((win == WIN_CTX) && !(thr_sel || cpl_sel)));

endmodule

// File: rtl/intc_source_state.sv
module intc_source_state
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SOURCES = 32,
  localparam int unsigned IDW = $clog2(NUM_SOURCES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           prio_we_i,
  input  logic [IDW-1:0]                 prio_id_i,
  input  logic [PRIO_BITS-1:0]           prio_val_i,
  input  logic [NUM_SOURCES-1:0]         level_i,
  input  logic                           claim_valid_i,
  input  logic [IDW-1:0]                 claim_id_i,
  input  logic                           cpl_we_i,
  input  logic [IDW-1:0]                 cpl_id_i,
  output logic [NUM_SOURCES*PRIO_BITS-1:0] prio_o,
  output logic [NUM_SOURCES-1:0]         active_o
);

  logic [PRIO_BITS-1:0]   prio_q [NUM_SOURCES];
  logic [NUM_SOURCES-1:0] pend_q, pend_d;
  logic [NUM_SOURCES-1:0] clm_q, clm_d;
  logic                   flag_en;

  // Next state of the pending and claimed bitmaps; a claim wins over a
  // completion of the same source in the same cycle.
  always_comb begin
    clm_d = clm_q;
    if (cpl_we_i)      clm_d[cpl_id_i]   = 1'b0;
    if (claim_valid_i) clm_d[claim_id_i] = 1'b1;
    clm_d[0] = 1'b0;
    pend_d = pend_q | (level_i & ~clm_q);
    if (claim_valid_i) pend_d[claim_id_i] = 1'b0;
    pend_d[0] = 1'b0;
  end

  assign flag_en = claim_valid_i || cpl_we_i || (|level_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      clm_q  <= '0;
    end else if (flag_en) begin
      pend_q <= pend_d;
      clm_q  <= clm_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SOURCES; s++) prio_q[s] <= '0;
    end else if (prio_we_i && (prio_id_i != '0)) begin
      prio_q[prio_id_i] <= prio_val_i;
    end
  end

  assign active_o = pend_q & ~clm_q;

  for (genvar s = 0; s < NUM_SOURCES; s++) begin : g_src
    assign prio_o[s*PRIO_BITS +: PRIO_BITS] = prio_q[s];
    if (s != 0) begin : g_chk
      // R1: the addressed source keeps the written low bits
      p_prio_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prio_we_i && (prio_id_i == IDW'(s))) |=> (prio_q[s] == $past(prio_val_i)));
    end
  end

  // R8: a claim leaves its source claimed and not pending
  p_claim_effect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_valid_i && (claim_id_i != '0)) |=>
      (clm_q[$past(claim_id_i)] && !pend_q[$past(claim_id_i)]));

endmodule

// File: rtl/intc_context_eval.sv
module intc_context_eval
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SOURCES = 32,
  localparam int unsigned NUM_WORDS = (NUM_SOURCES + 31) / 32,
  localparam int unsigned WW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned EN_BITS   = NUM_WORDS * 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_we_i,
  input  logic [WW-1:0]                    en_word_i,
  input  logic [31:0]                      en_data_i,
  input  logic                             thr_we_i,
  input  logic [PRIO_BITS-1:0]             thr_val_i,
  input  logic [NUM_SOURCES*PRIO_BITS-1:0] prio_i,
  input  logic [NUM_SOURCES-1:0]           active_i,
  output logic                             irq_o
);

  logic [EN_BITS-1:0]     en_q, en_d;
  logic [PRIO_BITS-1:0]   thr_q;
  logic [NUM_SOURCES-1:0] above;

  always_comb begin
    en_d = en_q;
    en_d[en_word_i*32 +: 32] = en_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_we_i) thr_q <= thr_val_i;
  end

  for (genvar s = 0; s < NUM_SOURCES; s++) begin : g_cmp
    assign above[s] = prio_i[s*PRIO_BITS +: PRIO_BITS] > thr_q;
  end

  assign irq_o = |(active_i & en_q[NUM_SOURCES-1:0] & above);

  // R9: strict comparison means the top threshold masks everything
  p_irq_thr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (thr_q != PRIO_BITS'(MAX_PRIO)));

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SOURCES    = 32,
  parameter int unsigned NUM_CONTEXTS   = 2,
  parameter int unsigned ENABLE_STRIDE  = 'h80,
  parameter int unsigned CONTEXT_STRIDE = 'h1000,
  parameter logic [31:0] PRIO_BASE      = 32'h0,
  parameter logic [31:0] PEND_BASE      = 32'h1000,
  parameter logic [31:0] EN_BASE        = 32'h2000,
  parameter logic [31:0] CTX_BASE       = 32'h200000,
  localparam int unsigned IDW       = $clog2(NUM_SOURCES),
  localparam int unsigned CW        = (NUM_CONTEXTS > 1) ? $clog2(NUM_CONTEXTS) : 1,
  localparam int unsigned NUM_WORDS = (NUM_SOURCES + 31) / 32,
  localparam int unsigned WW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_valid_i,
  input  logic [31:0]             wr_addr_i,
  input  logic [31:0]             wr_data_i,
  input  logic [NUM_SOURCES-1:0]  src_level_i,
  input  logic                    claim_valid_i,
  input  logic [IDW-1:0]          claim_id_i,
  output logic [NUM_CONTEXTS-1:0] irq_o,
  output logic                    err_o
);

  logic           prio_we, en_we, thr_we, cpl_we, illegal;
  logic [IDW-1:0] prio_id, cpl_id;
  logic [CW-1:0]  en_ctx, ctx;
  logic [WW-1:0]  en_word;
  logic [NUM_SOURCES*PRIO_BITS-1:0] prio_flat;
  logic [NUM_SOURCES-1:0] active;
  logic           err_q;

  intc_write_decode #(
    .NUM_SOURCES(NUM_SOURCES), .NUM_CONTEXTS(NUM_CONTEXTS),
    .ADDR_W(32), .DATA_W(32),
    .ENABLE_STRIDE(ENABLE_STRIDE), .CONTEXT_STRIDE(CONTEXT_STRIDE),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .CTX_BASE(CTX_BASE)
  ) i_dec (
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .prio_we_o(prio_we), .prio_id_o(prio_id),
    .en_we_o(en_we), .en_ctx_o(en_ctx), .en_word_o(en_word),
    .thr_we_o(thr_we), .cpl_we_o(cpl_we), .ctx_o(ctx),
    .cpl_id_o(cpl_id), .illegal_o(illegal)
  );

  intc_source_state #(.NUM_SOURCES(NUM_SOURCES)) i_src (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prio_we_i(prio_we), .prio_id_i(prio_id),
    .prio_val_i(wr_data_i[PRIO_BITS-1:0]),
    .level_i(src_level_i),
    .claim_valid_i(claim_valid_i), .claim_id_i(claim_id_i),
    .cpl_we_i(cpl_we), .cpl_id_i(cpl_id),
    .prio_o(prio_flat), .active_o(active)
  );

  for (genvar c = 0; c < NUM_CONTEXTS; c++) begin : g_ctx
    intc_context_eval #(.NUM_SOURCES(NUM_SOURCES)) i_ctx (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .en_we_i(en_we && (en_ctx == CW'(c))),
      .en_word_i(en_word), .en_data_i(wr_data_i),
      .thr_we_i(thr_we && (ctx == CW'(c))),
      .thr_val_i(wr_data_i[PRIO_BITS-1:0]),
      .prio_i(prio_flat), .active_i(active),
      .irq_o(irq_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= illegal;
  end

  assign err_o = err_q;

  // R7: an error pulse is always caused by a write one edge earlier
  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_valid_i));

  // R4: an over-range threshold value is flagged
  p_thr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && (wr_addr_i == CTX_BASE) && (wr_data_i > 32'(MAX_PRIO))) |=> err_o);

  // R5: an over-range completion ID is flagged
  p_cpl_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && (wr_addr_i == CTX_BASE + 32'd4) &&
     (wr_data_i >= 32'(NUM_SOURCES))) |=> err_o);

endmodule

// File: tb/test_intc_regfile.sv
`timescale 1ns/1ps
module test_intc_regfile;

  localparam int NS = 32;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [31:0]   wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [NS-1:0] level = '0;
  logic          claim_valid = 1'b0;
  logic [4:0]    claim_id = '0;
  logic [NC-1:0] irq;
  logic          err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  intc_regfile i_intc_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .src_level_i(level),
    .claim_valid_i(claim_valid), .claim_id_i(claim_id),
    .irq_o(irq), .err_o(err)
  );

  // Vector layout: addr, data, level, expected err, expected irq[1:0].
  localparam int NV = 16;
  localparam logic [98:0] VEC [NV] = '{
    {32'h0000_0008, 32'h0000_000D, 32'h0, 1'b0, 2'b00}, // R1 src3 prio 5
    {32'h0000_2000, 32'h0000_0008, 32'h0, 1'b0, 2'b00}, // R3 ctx0 en src3
    {32'h0020_0000, 32'h0000_0004, 32'h8, 1'b0, 2'b01}, // R4 R8 thr0=4, 5>4
    {32'h0020_0000, 32'h0000_0005, 32'h8, 1'b0, 2'b00}, // R9 5 not > 5
    {32'h0020_0000, 32'h0000_0008, 32'h8, 1'b1, 2'b00}, // R4 8 dropped
    {32'h0020_0000, 32'h0000_0002, 32'h8, 1'b0, 2'b01}, // R4 thr0=2
    {32'h0000_2080, 32'h0000_0008, 32'h8, 1'b0, 2'b11}, // R3 ctx1 en src3
    {32'h0000_1000, 32'h0000_0000, 32'h8, 1'b1, 2'b11}, // R2 pending untouched
    {32'h0000_2004, 32'h0000_0000, 32'h8, 1'b1, 2'b11}, // R3 word1 invalid
    {32'h0020_0008, 32'h0000_0000, 32'h8, 1'b1, 2'b11}, // R6 ctx offset 8
    {32'h0010_0000, 32'h0000_0000, 32'h8, 1'b1, 2'b11}, // R6 no window
    {32'h0000_0008, 32'h0000_0000, 32'h8, 1'b0, 2'b00}, // R9 prio 0 silent
    {32'h0000_0008, 32'hFFFF_FFFF, 32'h8, 1'b0, 2'b11}, // R1 low bits = 7
    {32'h0020_0004, 32'h0000_0020, 32'h8, 1'b1, 2'b11}, // R5 id 32 dropped
    {32'h0000_007C, 32'h0000_0001, 32'h8, 1'b1, 2'b11}, // R1 past window end
    {32'h0000_0078, 32'h0000_0001, 32'h8, 1'b0, 2'b11}  // R1 last reg, src31
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; return at the next falling edge,
  // after the rising edge that consumed the inputs.
  task automatic cycle(input logic v, input logic [31:0] a, input logic [31:0] d,
                       input logic [31:0] lv, input logic cv, input logic [4:0] cid);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; level = lv;
    claim_valid = cv; claim_id = cid;
    @(negedge clk);
    wr_valid = 1'b0; claim_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 irq after reset", 32'(irq), 32'h0);
    check("R10 err after reset", 32'(err), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cycle(1'b1, VEC[i][98:67], VEC[i][66:35], VEC[i][34:3], 1'b0, 5'd0);
      check($sformatf("R7 err vector %0d", i), 32'(err), 32'(VEC[i][2]));
      check($sformatf("R9 irq vector %0d", i), 32'(irq), 32'(VEC[i][1:0]));
    end

    // R7: the error pulse lasts one cycle
    cycle(1'b1, 32'h0010_0000, 32'h0, 32'h8, 1'b0, 5'd0);
    check("R7 pulse high", 32'(err), 32'h1);
    cycle(1'b0, 32'h0, 32'h0, 32'h8, 1'b0, 5'd0);
    check("R7 pulse one cycle", 32'(err), 32'h0);

    // R8: claim removes the request and blocks new pending while claimed
    cycle(1'b0, 32'h0, 32'h0, 32'h8, 1'b1, 5'd3);
    check("R8 claim drops irq", 32'(irq), 32'h0);
    cycle(1'b0, 32'h0, 32'h0, 32'h8, 1'b0, 5'd0);
    check("R8 level ignored while claimed", 32'(irq), 32'h0);

    // R5: completion through context 1 releases the source
    cycle(1'b1, 32'h0020_1004, 32'h3, 32'h8, 1'b0, 5'd0);
    check("R5 complete no err", 32'(err), 32'h0);
    check("R5 pending still clear", 32'(irq), 32'h0);
    cycle(1'b0, 32'h0, 32'h0, 32'h8, 1'b0, 5'd0);
    check("R5 R8 re-pend after complete", 32'(irq), 32'h3);

    // R10: mid-run reset clears all state
    @(negedge clk);
    level = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    cycle(1'b1, 32'h0000_0000, 32'h1, 32'h2, 1'b0, 5'd0);
    check("R10 enables cleared", 32'(irq), 32'h0);
    cycle(1'b1, 32'h0000_2000, 32'h2, 32'h2, 1'b0, 5'd0);
    check("R10 R9 thr reset to 0", 32'(irq), 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule